// File: doc/BRIEF.md
# Request-Triggered Sensor Result Responder

This block is the device end of a request/response sensor link whose data phase runs as an SPI slave. The host starts a measurement by pulling the active-low request input low. The block filters out pulses that are too short. It then holds a measurement-enable output high for a programmable number of clock cycles. This window stands in for the analog acquisition. At the end of the window the block captures a supplied 16-bit value as the result.

If the host has released the request by the end of the window, the block asserts its active-low data-ready line and waits for the host to clock the result out on SDO. If the request is still held, the block moves to a setup state instead and sends nothing.

Both SDO and data-ready leave the block as a value plus a pad driver enable. Outside a transfer the enables are low, so several responders can share one SCK/SDO/data-ready bus, each with its own request line. The SCK idle level and the launching edge are both configuration inputs. A second byte that starts too soon after the first is flagged.

Top module: `sense_req_responder`

## Requirements
- R1: A request low time, measured after the two-flop synchronizer, shorter than REQ_MIN_US*CYC_PER_US clock cycles is ignored: meas_en stays low and no transfer follows.
- R2: A request held low for at least that many cycles starts an acquisition, and meas_en is high for exactly acq_len consecutive cycles. An acq_len of 0 counts as 1.
- R3: If the synchronized request is still low when the acquisition ends, setup_mode goes high and drdy_oe stays low. setup_mode drops once the request returns high, and the block is then idle.
- R4: If the request is high when the acquisition ends, meas_value is captured in that cycle, drdy_oe goes high and drdy_n_o is 0.
- R5: The captured word leaves on sdo_o as bits 15 down to 0: the high byte first, each byte MSB first.
- R6: cpol gives the SCK idle level (0 low, 1 high). A leading edge moves SCK away from idle and a trailing edge moves it back. With launch_lead=1, sdo_o changes on leading edges, the first leading edge presents bit 15, and the host samples on trailing edges. With launch_lead=0, bit 15 is valid as soon as data-ready asserts, sdo_o changes on trailing edges, and the host samples on leading edges.
- R7: sdo_oe and drdy_oe are 1 only while a transfer is in progress. SCK activity outside a transfer has no effect on the enables or on the next result.
- R8: After the 16th sampling edge, both enables return to 0 and the block goes idle. Another request is needed for another result.
- R9: If the first leading edge of the second byte comes no more than GAP_US*CYC_PER_US cycles after the 8th sampling edge, gap_err pulses high for one cycle. A longer gap gives no pulse. The transfer carries on either way.
- R10: meas_en is high only during acquisition. It is low while idle, while a request is being qualified, during a transfer and in setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 1 | Active-low measurement request, asynchronous |
| sck | input | 1 | Serial clock from the host, asynchronous |
| cpol | input | 1 | SCK idle level |
| launch_lead | input | 1 | 1: data changes on leading edges; 0: on trailing edges |
| acq_len | input | CNT_W | Acquisition window length in clock cycles |
| meas_value | input | WORD_W | Result value captured at the end of acquisition |
| meas_en | output | 1 | High during the acquisition window |
| setup_mode | output | 1 | High while in the setup state |
| sdo_o | output | 1 | Serial data value |
| sdo_oe | output | 1 | Driver enable for sdo_o |
| drdy_n_o | output | 1 | Active-low data-ready value |
| drdy_oe | output | 1 | Driver enable for drdy_n_o |
| gap_err | output | 1 | One-cycle pulse on an inter-byte gap violation |

## Verification
The embedded assertions check the following on every cycle:
- data-ready only rises straight after an acquisition;
- setup is only entered from an acquisition that ended with the request still low;
- acquisition only begins while the request is low;
- the shift register is frozen outside a transfer;
- both drivers are released right after the final sampling edge;
- a gap error only follows a leading SCK edge.

Several behaviours need whole host scenarios and only the bench's runs can show them:
- the exact width threshold of the request filter and the exact length of the acquisition window;
- the bit order seen in each of the four clock modes;
- that idle SCK toggling leaves the next result intact;
- that a short inter-byte gap is flagged while a long one is not.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_ACQ,
    ST_SEND,
    ST_SETUP
  } sr_state_e;

  // Converts a time in microseconds to clock cycles.
  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned cyc_per_us);
    return us * cyc_per_us;
  endfunction

  // Leading edge: SCK moves away from its idle level.
  function automatic logic leading_edge(input logic rise, input logic fall, input logic idle_hi);
    return idle_hi ? fall : rise;
  endfunction

  // Trailing edge: SCK returns to its idle level.
  function automatic logic trailing_edge(input logic rise, input logic fall, input logic idle_hi);
    return idle_hi ? rise : fall;
  endfunction

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sr_sck_edge.sv
module sr_sck_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic idle_hi,
  input  logic launch_lead,
  output logic lead_ev,
  output logic trail_ev,
  output logic sample_ev,
  output logic launch_ev
);
  logic sck_d;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign rise      = sck_s & ~sck_d;
  assign fall      = ~sck_s & sck_d;
  assign lead_ev   = sr_pkg::leading_edge(rise, fall, idle_hi);
  assign trail_ev  = sr_pkg::trailing_edge(rise, fall, idle_hi);
  assign sample_ev = launch_lead ? trail_ev : lead_ev;
  assign launch_ev = launch_lead ? lead_ev : trail_ev;
endmodule

// File: rtl/sr_tx_shift.sv
module sr_tx_shift #(
  parameter int WORD_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int GAP_CYC = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              active,
  input  logic              sample_ev,
  input  logic              launch_ev,
  input  logic              lead_ev,
  output logic              bit_o,
  output logic              done,
  output logic              gap_err
);
  localparam int BC_W = $clog2(WORD_W + 1);
  localparam int GC_W = $clog2(GAP_CYC + 1);
  localparam logic [BC_W-1:0] LAST_BIT   = BC_W'(WORD_W - 1);
  localparam logic [BC_W-1:0] BYTE_LAST  = BC_W'(BYTE_W - 1);
  localparam logic [BC_W-1:0] BYTE_FIRST = BC_W'(BYTE_W);
  localparam logic [GC_W-1:0] GAP_LIM    = GC_W'(GAP_CYC);

  logic [WORD_W-1:0] shreg;
  logic [BC_W-1:0]   bit_cnt;
  logic [GC_W-1:0]   gap_cnt;
  logic              gap_short;

  // A leading edge of the second byte that arrives while the gap count is under the limit.
  assign gap_short = active && lead_ev && (bit_cnt == BYTE_FIRST) && (gap_cnt < GAP_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      gap_cnt <= '0;
      gap_err <= 1'b0;
    end else begin
      gap_err <= gap_short;
      if (load) begin
        shreg   <= load_data;
        bit_cnt <= '0;
        gap_cnt <= '0;
      end else if (active) begin
        if (launch_ev && bit_cnt != '0)
          shreg <= {shreg[WORD_W-2:0], 1'b0};
        if (sample_ev) begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BYTE_LAST) gap_cnt <= '0;
        end else if (gap_cnt < GAP_LIM) begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end
    end
  end

  assign bit_o = shreg[WORD_W-1];
  assign done  = active && sample_ev && (bit_cnt == LAST_BIT);

  assert_gap_err_follows_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |-> ($past(lead_ev) && $past(active)));

  assert_shreg_frozen_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> $stable(shreg));

  assert_bitcnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bit_cnt < BC_W'(WORD_W)));
endmodule

// File: rtl/sense_req_responder.sv
module sense_req_responder #(
  parameter int CYC_PER_US = 100,
  parameter int REQ_MIN_US = 30,
  parameter int GAP_US     = 12,
  parameter int WORD_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              sck,
  input  logic              cpol,
  input  logic              launch_lead,
  input  logic [CNT_W-1:0]  acq_len,
  input  logic [WORD_W-1:0] meas_value,
  output logic              meas_en,
  output logic              setup_mode,
  output logic              sdo_o,
  output logic              sdo_oe,
  output logic              drdy_n_o,
  output logic              drdy_oe,
  output logic              gap_err
);
  import sr_pkg::*;

  localparam int unsigned REQ_MIN_CYC = us_to_cycles(REQ_MIN_US, CYC_PER_US);
  localparam int unsigned GAP_CYC     = us_to_cycles(GAP_US, CYC_PER_US);
  localparam logic [CNT_W-1:0] REQ_LIM = CNT_W'(REQ_MIN_CYC - 1);

  function automatic logic [CNT_W-1:0] last_acq_cycle(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  sr_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             req_s, sck_s;
  logic             lead_ev, trail_ev, sample_ev, launch_ev;
  logic             talking, acq_end, tx_load, tx_done, tx_bit;

  sr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_s)
  );

  sr_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s)
  );

  sr_sck_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .idle_hi(cpol),
    .launch_lead(launch_lead), .lead_ev(lead_ev), .trail_ev(trail_ev),
    .sample_ev(sample_ev), .launch_ev(launch_ev)
  );

  // Named events for the assertions and the shifter.
  assign acq_end = (state == ST_ACQ) && (cnt >= last_acq_cycle(acq_len));
  assign tx_load = acq_end && req_s;
  assign talking = (state == ST_SEND);

  sr_tx_shift #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .GAP_CYC(GAP_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(meas_value),
    .active(talking), .sample_ev(sample_ev), .launch_ev(launch_ev),
    .lead_ev(lead_ev), .bit_o(tx_bit), .done(tx_done), .gap_err(gap_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (!req_s) begin
          state <= ST_ARM;
          cnt   <= CNT_W'(1);
        end
        ST_ARM: begin
          if (req_s) begin
            state <= ST_IDLE;
          end else if (cnt >= REQ_LIM) begin
            state <= ST_ACQ;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACQ: begin
          if (acq_end) begin
            state <= req_s ? ST_SEND : ST_SETUP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SEND:  if (tx_done) state <= ST_IDLE;
        ST_SETUP: if (req_s)   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign meas_en    = (state == ST_ACQ);
  assign setup_mode = (state == ST_SETUP);
  assign sdo_oe     = talking;
  assign drdy_oe    = talking;
  assign drdy_n_o   = ~talking;
  assign sdo_o      = talking & tx_bit;

  assert_drdy_after_acq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_oe) |-> $past(meas_en));

  assert_setup_after_held_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_mode) |-> ($past(meas_en) && !$past(req_s)));

  assert_acq_needs_low_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_en) |-> !$past(req_s));

  assert_release_after_last_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (!drdy_oe && !sdo_oe));

  assert_no_meas_while_talking_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(talking) |=> !meas_en);
endmodule

// File: tb/test_sense_req_responder.sv
module test_sense_req_responder;
  localparam int CPU  = 2;
  localparam int MINW = 30 * CPU;
  localparam int HALF = 6;

  typedef struct packed {
    logic        pol;
    logic        lead;
    logic [15:0] val;
    logic [15:0] alen;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 16'hA5C3, 16'd40},
    '{1'b0, 1'b1, 16'h0001, 16'd100},
    '{1'b1, 1'b0, 16'h8000, 16'd55},
    '{1'b1, 1'b1, 16'hFFFF, 16'd200},
    '{1'b0, 1'b1, 16'h3C96, 16'd47},
    '{1'b1, 1'b0, 16'h00FF, 16'd64}
  };

  logic clk = 0, rst_n = 0, req_n = 1, sck = 0, cpol = 0, launch_lead = 0;
  logic [15:0] acq_len = 16'd40, meas_value = 16'h0;
  logic meas_en, setup_mode, sdo_o, sdo_oe, drdy_n_o, drdy_oe, gap_err;
  int checks = 0, errors = 0, meas_cycles = 0, gap_pulses = 0;

  always #5 clk = ~clk;

  sense_req_responder #(.CYC_PER_US(CPU)) i_sense_req_responder (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .sck(sck), .cpol(cpol),
    .launch_lead(launch_lead), .acq_len(acq_len), .meas_value(meas_value),
    .meas_en(meas_en), .setup_mode(setup_mode), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .drdy_n_o(drdy_n_o), .drdy_oe(drdy_oe), .gap_err(gap_err)
  );

  always @(posedge clk) begin
    if (meas_en) meas_cycles <= meas_cycles + 1;
    if (gap_err) gap_pulses  <= gap_pulses + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_req(input int width);
    @(negedge clk);
    req_n = 1'b0;
    repeat (width) @(negedge clk);
    req_n = 1'b1;
  endtask

  task automatic wait_drdy(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (drdy_oe) seen = 1;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic read_word(input logic pol, input logic lead, input int gap, output logic [15:0] w);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      if (i == 8) repeat (gap) @(negedge clk);
      if (!lead) w = {w[14:0], sdo_o};
      sck = ~pol;
      repeat (HALF) @(negedge clk);
      if (lead) w = {w[14:0], sdo_o};
      sck = pol;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic set_mode(input logic pol, input logic lead);
    cpol = pol;
    launch_lead = lead;
    sck = pol;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    bit seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state (R7, R10)
    check(sdo_oe == 0 && drdy_oe == 0, "R7 reset enables", {sdo_oe, drdy_oe}, 0);
    check(meas_en == 0, "R10 reset meas_en", meas_en, 0);
    check(setup_mode == 0, "R3 reset setup_mode", setup_mode, 0);

    // Vector table: four clock modes, several values and lengths
    foreach (VECS[k]) begin
      set_mode(VECS[k].pol, VECS[k].lead);
      meas_value  = VECS[k].val;
      acq_len     = VECS[k].alen;
      meas_cycles = 0;
      gap_pulses  = 0;
      pulse_req(MINW + 20);
      wait_drdy(seen);
      check(seen && drdy_n_o == 0, "R4 data-ready asserted", drdy_n_o, 0);
      check(meas_cycles == int'(VECS[k].alen), "R2 acquisition length", meas_cycles, VECS[k].alen);
      check(meas_en == 0, "R10 meas_en low in transfer", meas_en, 0);
      read_word(VECS[k].pol, VECS[k].lead, 30, w);
      check(w == VECS[k].val, "R5 R6 word order", w, VECS[k].val);
      check(sdo_oe == 0 && drdy_oe == 0, "R8 release after 16 bits", {sdo_oe, drdy_oe}, 0);
      check(gap_pulses == 0, "R9 long gap not flagged", gap_pulses, 0);
    end

    // Short request ignored (R1)
    set_mode(1'b0, 1'b1);
    meas_cycles = 0;
    acq_len = 16'd50;
    pulse_req(MINW - 2);
    repeat (200) @(negedge clk);
    check(meas_cycles == 0, "R1 short request ignored", meas_cycles, 0);
    check(drdy_oe == 0, "R1 no transfer after short request", drdy_oe, 0);

    // Just over the threshold accepted (R1, R2)
    meas_value = 16'h5A17;
    acq_len = 16'd60;
    meas_cycles = 0;
    pulse_req(MINW + 2);
    wait_drdy(seen);
    check(seen, "R1 threshold request accepted", seen, 1);
    check(meas_cycles == 60, "R2 window after threshold request", meas_cycles, 60);
    read_word(1'b0, 1'b1, 30, w);
    check(w == 16'h5A17, "R5 threshold request data", w, 16'h5A17);

    // Held request diverts to setup (R3)
    acq_len = 16'd50;
    meas_cycles = 0;
    @(negedge clk);
    req_n = 1'b0;
    repeat (MINW + 100) @(negedge clk);
    check(setup_mode == 1, "R3 setup entered", setup_mode, 1);
    check(drdy_oe == 0, "R3 no data-ready in setup", drdy_oe, 0);
    req_n = 1'b1;
    repeat (10) @(negedge clk);
    check(setup_mode == 0, "R3 setup left on release", setup_mode, 0);

    // Zero length counts as one cycle; request still low gives setup (R2, R3)
    acq_len = 16'd0;
    meas_cycles = 0;
    pulse_req(MINW + 20);
    repeat (10) @(negedge clk);
    check(meas_cycles == 1, "R2 zero length window", meas_cycles, 1);
    check(setup_mode == 0 && drdy_oe == 0, "R3 zero length setup then idle", {setup_mode, drdy_oe}, 0);

    // SCK toggling while idle has no effect (R7)
    set_mode(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      sck = ~sck;
      repeat (HALF) @(negedge clk);
      check(sdo_oe == 0 && drdy_oe == 0, "R7 idle SCK ignored", {sdo_oe, drdy_oe}, 0);
    end
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    meas_value = 16'hC3E1;
    acq_len = 16'd70;
    pulse_req(MINW + 20);
    wait_drdy(seen);
    read_word(1'b1, 1'b0, 30, w);
    check(w == 16'hC3E1, "R7 result intact after idle SCK", w, 16'hC3E1);

    // Short inter-byte gap flagged (R9)
    set_mode(1'b1, 1'b1);
    meas_value = 16'h6B2D;
    acq_len = 16'd45;
    gap_pulses = 0;
    pulse_req(MINW + 20);
    wait_drdy(seen);
    read_word(1'b1, 1'b1, 0, w);
    check(gap_pulses == 1, "R9 short gap flagged once", gap_pulses, 1);
    check(w == 16'h6B2D, "R9 transfer continues after gap error", w, 16'h6B2D);
    check(sdo_oe == 0, "R8 release after flagged transfer", sdo_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule